// File: doc/BRIEF.md
# Indexed Vertex Sequencer with Post-Transform Tag Cache

This block turns one draw command into a stream of vertex numbers, one per loop position. A flat (non-indexed) draw produces `offset + position`. An indexed draw reads one index per position from an index memory, and the index can be 8 or 16 bits wide. Each vertex that needs transformation is handed to an external processing stage through a request/acknowledge handshake. Each vertex leaves the block on an output stream that says whether its result already sits in a result-store slot, and which slot.

In indexed mode the block keeps a 32-entry fully associative table of vertex tags. Every index that arrives is compared against all tags in the same cycle. On a hit, the matching slot is reported and no processing is requested. On a miss, processing is requested. Once the processing stage acknowledges, the tag is written into the slot named by a circular write pointer. The table is emptied and the pointer is rewound at the start of every draw. A 16-bit index of all ones cannot be told apart from an empty tag. Such an index is refused and raises an error flag.

Top module: `vtx_fetch_seq`

## Requirements
- R1: After reset, `busy_o`, `out_valid_o`, `done_o`, `err_o`, `imem_rd_o` and `proc_req_o` are all low.
- R2: In a flat draw (`indexed_i`=0), output k carries vertex `(offset + k) mod 2^16` with `out_hit_o`=0 and `out_slot_o`=0. Every vertex goes through one processing handshake, and the index memory is never read.
- R3: In an indexed draw with `idx16_i`=0, output k carries bits [7:0] of index-memory word k, zero-extended. Bits [15:8] of the word and the draw offset have no effect.
- R4: In an indexed draw with `idx16_i`=1, output k carries all 16 bits of index-memory word k.
- R5: In an indexed draw, a vertex whose tag is present gives `out_hit_o`=1 and the slot holding it (the lowest such slot). No processing request is made for it.
- R6: In an indexed draw, a vertex that misses raises `proc_req_o` with `proc_vtx_o` held steady until `proc_ack_i`. The vertex is then written to the slot at the write pointer and reported with `out_hit_o`=0 and that slot. The pointer then advances by one, wrapping from 31 to 0.
- R7: Each accepted start empties the tag table and sets the write pointer to slot 0. As a result, the first miss of every indexed draw fills slot 0.
- R8: A draw emits exactly `count_i` outputs, in position order. A count of zero emits none.
- R9: `done_o` pulses for one cycle, one cycle after the last output. For a count of zero it pulses in the second cycle after the start is sampled.
- R10: In 16-bit mode, index 0xFFFF sets `err_o`, which stays high until the next accepted start. The vertex is output with `out_hit_o`=0 and slot 0, with no processing request and no table fill. The 8-bit value 0xFF is a legal index.
- R11: While `busy_o` is high, `start_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Draw start, sampled while idle |
| indexed_i | input | 1 | 1 = indexed draw, 0 = flat draw |
| idx16_i | input | 1 | Index width: 1 = 16-bit, 0 = 8-bit |
| count_i | input | 16 | Number of vertices in the draw |
| offset_i | input | 16 | First vertex number of a flat draw |
| busy_o | output | 1 | A draw is in progress |
| imem_rd_o | output | 1 | Index memory read strobe |
| imem_addr_o | output | 16 | Index memory word address (loop position) |
| imem_rdata_i | input | 16 | Index word, valid the cycle after the strobe |
| proc_req_o | output | 1 | Vertex processing request |
| proc_vtx_o | output | 16 | Vertex number to process |
| proc_ack_i | input | 1 | Processing done for the requested vertex |
| out_valid_o | output | 1 | Output vertex valid (one-cycle pulse) |
| out_vtx_o | output | 16 | Output vertex number |
| out_hit_o | output | 1 | Vertex result found in the table |
| out_slot_o | output | 5 | Slot holding the vertex result |
| done_o | output | 1 | Draw complete pulse |
| err_o | output | 1 | Illegal index seen in this draw |

## Verification
Each output appears in the cycle after the edge that decides it. For an indexed hit, that edge is two edges after the read strobe. For a miss, or for any flat vertex, it is the edge on which the acknowledge is sampled. `done_o` comes exactly one cycle after the last output. The bench samples on the falling edge and records the cycle of every output pulse. It checks `done_o` against the last recorded output cycle, or against the start cycle for an empty draw. It varies the acknowledge delay from zero to two cycles. It compares the vertex, hit flag and slot of every output with a reference built from the requirements: a 32-tag table with a circular pointer. `err_o` and the number of handshakes and memory reads are checked once `done_o` has arrived.

// File: rtl/vtx_pkg.sv
package vtx_pkg;
  localparam int unsigned VTX_W   = 16;
  localparam int unsigned ENTRIES = 32;
  localparam int unsigned NARROW  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOOK,
    ST_PROC,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/vtx_idx_sel.sv
module vtx_idx_sel #(
  parameter int unsigned VTX_W  = 16,
  parameter int unsigned NARROW = 8
) (
  input  logic [VTX_W-1:0] raw_i,
  input  logic             wide_i,
  output logic [VTX_W-1:0] vtx_o,
  output logic             bad_o
);
  always_comb begin
    if (wide_i) vtx_o = raw_i;
    else        vtx_o = {{(VTX_W-NARROW){1'b0}}, raw_i[NARROW-1:0]};
  end

  // all-ones equals the empty-tag code, so it cannot be cached
  assign bad_o = wide_i && (&raw_i);
endmodule

// File: rtl/vtx_tag_cache.sv
module vtx_tag_cache #(
  parameter  int unsigned ENTRIES = 32,
  parameter  int unsigned TAG_W   = 16,
  localparam int unsigned SLOT_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] hit_slot_o,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  output logic [SLOT_W-1:0] wr_ptr_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(ENTRIES - 1);

  logic [TAG_W-1:0]  tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [SLOT_W-1:0] wr_ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tag_q[g] <= '1;
      else if (clr_i)                              tag_q[g] <= '1;
      else if (fill_i && wr_ptr_q == SLOT_W'(g))   tag_q[g] <= fill_tag_i;
    end
    assign match[g] = (tag_q[g] == look_tag_i);
  end

  // descending scan: the lowest matching slot is assigned last and wins
  always_comb begin
    hit_o      = 1'b0;
    hit_slot_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o      = 1'b1;
        hit_slot_o = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wr_ptr_q <= '0;
    else if (clr_i)  wr_ptr_q <= '0;
    else if (fill_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
  end

  assign wr_ptr_o = wr_ptr_q;

  // R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !clr_i |=> wr_ptr_o == (($past(wr_ptr_o) == LAST) ? '0 : $past(wr_ptr_o) + 1'b1));
  // R7
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!hit_o || (&look_tag_i)) && wr_ptr_o == '0);
endmodule

// File: rtl/vtx_fetch_seq.sv
module vtx_fetch_seq
  import vtx_pkg::*;
#(
  parameter  int unsigned W       = vtx_pkg::VTX_W,
  parameter  int unsigned N_SLOT  = vtx_pkg::ENTRIES,
  localparam int unsigned SLOT_W  = $clog2(N_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              indexed_i,
  input  logic              idx16_i,
  input  logic [W-1:0]      count_i,
  input  logic [W-1:0]      offset_i,
  output logic              busy_o,
  output logic              imem_rd_o,
  output logic [W-1:0]      imem_addr_o,
  input  logic [W-1:0]      imem_rdata_i,
  output logic              proc_req_o,
  output logic [W-1:0]      proc_vtx_o,
  input  logic              proc_ack_i,
  output logic              out_valid_o,
  output logic [W-1:0]      out_vtx_o,
  output logic              out_hit_o,
  output logic [SLOT_W-1:0] out_slot_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e state_q;
  logic mode_idx_q, fmt16_q, err_q, out_valid_q, out_hit_q, done_q;
  logic [W-1:0] cnt_q, off_q, pos_q, vtx_q, out_vtx_q;
  logic [SLOT_W-1:0] out_slot_q;

  logic [W-1:0] sel_vtx, pos_nx;
  logic sel_bad, c_hit, c_clr, c_fill, emit, last;
  logic [SLOT_W-1:0] c_slot, c_ptr;
  logic [W-1:0] emit_vtx;
  logic emit_hit;
  logic [SLOT_W-1:0] emit_slot;

  vtx_idx_sel #(.VTX_W(W), .NARROW(vtx_pkg::NARROW)) i_sel (
    .raw_i  (imem_rdata_i),
    .wide_i (fmt16_q),
    .vtx_o  (sel_vtx),
    .bad_o  (sel_bad)
  );

  vtx_tag_cache #(.ENTRIES(N_SLOT), .TAG_W(W)) i_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (c_clr),
    .look_tag_i (sel_vtx),
    .hit_o      (c_hit),
    .hit_slot_o (c_slot),
    .fill_i     (c_fill),
    .fill_tag_i (vtx_q),
    .wr_ptr_o   (c_ptr)
  );

  assign c_clr  = (state_q == ST_IDLE) && start_i;
  assign pos_nx = pos_q + 1'b1;
  assign last   = (pos_q == cnt_q - 1'b1);

  always_comb begin
    emit      = 1'b0;
    emit_vtx  = vtx_q;
    emit_hit  = 1'b0;
    emit_slot = '0;
    c_fill    = 1'b0;
    case (state_q)
      ST_LOOK: begin
        emit_vtx = sel_vtx;
        if (sel_bad) begin
          emit = 1'b1;
        end else if (c_hit) begin
          emit      = 1'b1;
          emit_hit  = 1'b1;
          emit_slot = c_slot;
        end
      end
      ST_PROC: begin
        if (proc_ack_i) begin
          emit   = 1'b1;
          c_fill = mode_idx_q;
          if (mode_idx_q) emit_slot = c_ptr;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_idx_q  <= 1'b0;
      fmt16_q     <= 1'b0;
      err_q       <= 1'b0;
      cnt_q       <= '0;
      off_q       <= '0;
      pos_q       <= '0;
      vtx_q       <= '0;
      out_valid_q <= 1'b0;
      out_vtx_q   <= '0;
      out_hit_q   <= 1'b0;
      out_slot_q  <= '0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          mode_idx_q <= indexed_i;
          fmt16_q    <= idx16_i;
          cnt_q      <= count_i;
          off_q      <= offset_i;
          pos_q      <= '0;
          vtx_q      <= offset_i;
          err_q      <= 1'b0;
          if (count_i == '0)  state_q <= ST_FIN;
          else if (indexed_i) state_q <= ST_FETCH;
          else                state_q <= ST_PROC;
        end
        ST_FETCH: state_q <= ST_LOOK;
        ST_LOOK: begin
          if (sel_bad) err_q <= 1'b1;
          if (!emit) begin
            vtx_q   <= sel_vtx;
            state_q <= ST_PROC;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: ;
      endcase
      if (emit) begin
        out_valid_q <= 1'b1;
        out_vtx_q   <= emit_vtx;
        out_hit_q   <= emit_hit;
        out_slot_q  <= emit_slot;
        if (last) begin
          state_q <= ST_FIN;
        end else begin
          pos_q   <= pos_nx;
          vtx_q   <= off_q + pos_nx;
          state_q <= mode_idx_q ? ST_FETCH : ST_PROC;
        end
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign imem_rd_o   = (state_q == ST_FETCH);
  assign imem_addr_o = pos_q;
  assign proc_req_o  = (state_q == ST_PROC);
  assign proc_vtx_o  = vtx_q;
  assign out_valid_o = out_valid_q;
  assign out_vtx_o   = out_vtx_q;
  assign out_hit_o   = out_hit_q;
  assign out_slot_o  = out_slot_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_req_o && !proc_ack_i |=> proc_req_o && $stable(proc_vtx_o));
  // R2
  flat_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mode_idx_q |-> !imem_rd_o);
  // R2
  flat_no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !mode_idx_q |-> !out_hit_o && out_slot_o == '0);
  // R9
  done_after_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !out_valid_o);
  // R11
  busy_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mode_idx_q) && $stable(cnt_q));
  // R5
  hit_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_hit_o |-> $past(state_q) == ST_LOOK);
endmodule

// File: tb/test_vtx_fetch_seq.sv
module test_vtx_fetch_seq;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, indexed_i = 1'b0, idx16_i = 1'b0, proc_ack_i = 1'b0;
  logic [15:0] count_i = '0, offset_i = '0, imem_rdata_i = '0;
  logic busy_o, imem_rd_o, proc_req_o, out_valid_o, out_hit_o, done_o, err_o;
  logic [15:0] imem_addr_o, proc_vtx_o, out_vtx_o;
  logic [4:0] out_slot_o;

  int n_run = 0, n_fail = 0, n_reads = 0;
  bit finished = 1'b0;
  logic [15:0] mem [256];
  int mtag [32];
  int mptr;

  always #4 clk_i = ~clk_i;

  vtx_fetch_seq i_vtx_fetch_seq (
    .clk_i, .rst_ni, .start_i, .indexed_i, .idx16_i, .count_i, .offset_i,
    .busy_o, .imem_rd_o, .imem_addr_o, .imem_rdata_i, .proc_req_o, .proc_vtx_o,
    .proc_ack_i, .out_valid_o, .out_vtx_o, .out_hit_o, .out_slot_o, .done_o, .err_o
  );

  always @(posedge clk_i) begin
    if (imem_rd_o) begin
      imem_rdata_i <= mem[imem_addr_o[7:0]];
      n_reads <= n_reads + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic run_draw(input bit idx, input bit w16, input int cnt, input int off,
                          input int ack_dly, input bit poke, input string tag);
    int k = 0, cyc = 1, dly = 0, n_req = 0, exp_req = 0, last_out = -10;
    int reads0;
    bit exp_err = 1'b0;
    for (int i = 0; i < 32; i++) mtag[i] = -1;
    mptr = 0;
    reads0 = n_reads;
    @(negedge clk_i);
    start_i = 1'b1; indexed_i = idx; idx16_i = w16;
    count_i = 16'(cnt); offset_i = 16'(off);
    @(negedge clk_i);
    start_i = 1'b0;
    while (1) begin
      if (poke && cyc == 3) begin
        start_i = 1'b1; indexed_i = !idx; count_i = 16'd1; offset_i = 16'h5555;
      end else start_i = 1'b0;
      if (out_valid_o) begin
        int v, eh, es;
        last_out = cyc;
        eh = 0; es = 0;
        if (!idx) begin
          v = (off + k) & 16'hFFFF;
          exp_req++;
        end else begin
          v = w16 ? int'(mem[k]) : int'(mem[k][7:0]);
          if (w16 && v == 16'hFFFF) begin
            exp_err = 1'b1;   // R10 illegal index
          end else begin
            int hs = -1;
            for (int i = 31; i >= 0; i--) if (mtag[i] == v) hs = i;
            if (hs >= 0) begin eh = 1; es = hs; end
            else begin es = mptr; mtag[mptr] = v; mptr = (mptr + 1) % 32; exp_req++; end
          end
        end
        chk({tag, " R2/R3/R4 vertex"}, int'(out_vtx_o), v);
        chk({tag, " R5 hit"}, int'(out_hit_o), eh);
        chk({tag, " R6 slot"}, int'(out_slot_o), es);
        k++;
      end
      if (done_o) break;
      if (proc_ack_i) proc_ack_i = 1'b0;
      else if (proc_req_o) begin
        if (dly >= ack_dly) begin proc_ack_i = 1'b1; n_req++; dly = 0; end
        else dly++;
      end
      if (cyc > 3000) begin
        chk({tag, " R9 watchdog"}, 0, 1);
        summary();
      end
      @(negedge clk_i);
      cyc++;
    end
    chk({tag, " R8 output count"}, k, cnt);
    if (cnt == 0) chk({tag, " R9 done for zero count"}, cyc, 2);
    else          chk({tag, " R9 done cycle"}, cyc, last_out + 1);
    chk({tag, " R6 handshakes"}, n_req, exp_req);
    chk({tag, " R10 err"}, int'(err_o), int'(exp_err));
    if (!idx) chk({tag, " R2 no reads"}, n_reads - reads0, 0);
    @(negedge clk_i);
    chk({tag, " R9 done one cycle"}, int'(done_o), 0);
  endtask

  initial begin
    #1_000_000;
    chk("watchdog", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA500 | 16'((i * 7) % 5);
    #20;
    // R1
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 out_valid", int'(out_valid_o), 0);
    chk("R1 done/err", int'(done_o | err_o), 0);
    chk("R1 req/rd", int'(proc_req_o | imem_rd_o), 0);
    rst_ni = 1'b1;
    // R2 flat draws, incl. wrap of 16-bit vertex number
    run_draw(1'b0, 1'b0, 5, 100, 0, 1'b0, "flat");
    run_draw(1'b0, 1'b1, 4, 16'hFFFE, 2, 1'b0, "flatwrap");
    // R3 8-bit: upper byte garbage, offset ignored, repeats give hits
    run_draw(1'b1, 1'b0, 20, 777, 1, 1'b0, "idx8");
    // R4 16-bit with distinct wide values
    for (int i = 0; i < 24; i++) mem[i] = 16'(16'h1230 + (i % 9) * 16'h0101);
    run_draw(1'b1, 1'b1, 24, 0, 0, 1'b0, "idx16");
    // R7 second identical draw starts from an empty table
    run_draw(1'b1, 1'b1, 24, 0, 2, 1'b0, "refill");
    // R6 wrap: 33 distinct, then re-use evicted and kept ones
    for (int i = 0; i < 33; i++) mem[i] = 16'(i * 3);
    mem[33] = 16'd0; mem[34] = 16'd6; mem[35] = 16'd96;
    run_draw(1'b1, 1'b1, 36, 0, 0, 1'b0, "wrap");
    // R10 illegal wide index; 0xFF legal in narrow mode
    mem[0] = 16'd5; mem[1] = 16'hFFFF; mem[2] = 16'd9; mem[3] = 16'd5; mem[4] = 16'h00FF;
    run_draw(1'b1, 1'b1, 5, 0, 1, 1'b0, "bad16");
    run_draw(1'b1, 1'b0, 5, 0, 0, 1'b0, "ff8");
    // R8/R9 empty draw
    run_draw(1'b1, 1'b0, 0, 0, 0, 1'b0, "zero");
    // R11 start while busy ignored
    run_draw(1'b0, 1'b0, 6, 40, 1, 1'b1, "busy");
    run_draw(1'b1, 1'b0, 5, 0, 0, 1'b1, "busyidx");
    summary();
  end
endmodule